// File: doc/BRIEF.md
# Digital Black Level Clamp Loop

This block sits after the converter of an image sensor front end and keeps dark pixels at a chosen code. Pixel codes arrive one per valid cycle. The two interleaved readout channels are tracked apart by a parity flag that flips on each accepted pixel. A signed fixed-point offset is kept for each channel. The integer part of the offset for the current parity is added to the raw code, and the sum is clipped to the output range before it is registered.

While the dark-pixel calibration strobe is low, every accepted pixel updates the offset of its own parity. The update moves the offset toward the point where the corrected code equals the target. The target is picked from four values by a 2-bit select. Outside that window the offsets are frozen. A blanking strobe, also active low, zeroes the output, stops calibration and sends the parity back to even.

Top module: `black_level_clamp`

## Requirements
- R1: After reset, out_vld and out_data are 0 and both offsets are zero, so an uncalibrated pixel comes out equal to its raw code.
- R2: out_vld equals pix_vld delayed by one clock, including while blanking is active.
- R3: With blank_n high, a valid pixel with raw code X yields out_data = clip(X + floor(A/16)) on the next cycle, where A is the current parity's offset in units of 1/16 LSB. Cycles with pix_vld low and blank_n high leave out_data unchanged.
- R4: The parity is even (0) after reset and after any cycle with blank_n low. It flips after each valid pixel taken with blank_n high, and cycles with pix_vld low do not flip it.
- R5: On a valid pixel with ob_cal_n low and blank_n high, the current parity's offset A grows by 4·(T − C), where T is the target code and C is that pixel's corrected code. This is a quarter of the error in LSB.
- R6: ref_sel picks the target T: 00→16, 01→32, 10→48, 11→64. After calibration on dark pixels, the corrected output settles exactly on T.
- R7: With ob_cal_n high, neither offset changes.
- R8: A calibration pixel changes only the offset of its own parity, so channels with different dark levels each settle on T.
- R9: One cycle after blank_n is low, out_data is 0. A cycle with blank_n low updates no offset.
- R10: The corrected output saturates at 0 below and at 1023 above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld | input | 1 | Pixel code valid this cycle |
| pix_data | input | 10 | Raw pixel code |
| ob_cal_n | input | 1 | Dark-pixel calibration window, active low |
| blank_n | input | 1 | Blanking, active low: zero output, hold offsets, reset parity |
| ref_sel | input | 2 | Target black code select |
| out_vld | output | 1 | Output valid, one cycle after pix_vld |
| out_data | output | 10 | Corrected, clipped pixel code |

## Verification
A wrong offset shows on the very next non-calibration pixel of that parity as a constant shift from the raw code. During calibration it shows as a settling value other than the target. A parity slip swaps the two channel offsets, so alternating dark levels come out uneven one cycle after the slip. An update leaking into the frozen window, or into the other channel, appears at the next pixel of the affected parity. Any such error is visible within a cycle or two of its cause.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_e;

  // R6: target code = (sel + 1) * step, giving 16/32/48/64 at step 16
  function automatic int target_code(logic [1:0] sel, int step);
    return (int'(sel) + 1) * step;
  endfunction
endpackage

// File: rtl/blc_parity.sv
module blc_parity
  import blc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic blank_n,
  output par_e par
);
  always_ff @(posedge clk) begin
    if (!rst_n)        par <= PAR_EVEN;
    else if (!blank_n) par <= PAR_EVEN;
    else if (vld)      par <= (par == PAR_EVEN) ? PAR_ODD : PAR_EVEN;
  end

  p_even_after_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> par == PAR_EVEN);
  p_idle_keeps_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !vld) |=> $stable(par));
  p_valid_flips_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && vld) |=> par != $past(par));
endmodule

// File: rtl/blc_correct.sv
module blc_correct #(
  parameter int PIX_W  = 10,
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic [PIX_W-1:0]        raw,
  input  logic signed [ACC_W-1:0] acc,
  output logic [PIX_W-1:0]        corr
);
  localparam int SW = ACC_W + 1;
  localparam logic signed [SW-1:0] PMAX = SW'((1 << PIX_W) - 1);

  // R3/R10: raw + floor(acc / 2^FRAC_W), clipped to [0, 2^PIX_W-1]
  function automatic logic [PIX_W-1:0] apply_offset(logic [PIX_W-1:0] r,
                                                    logic signed [ACC_W-1:0] a);
    logic signed [SW-1:0] a_ext;
    logic signed [SW-1:0] s;
    a_ext = {a[ACC_W-1], a};
    s = $signed({{(SW-PIX_W){1'b0}}, r}) + (a_ext >>> FRAC_W);
    if (s < 0)         return '0;
    else if (s > PMAX) return {PIX_W{1'b1}};
    else               return s[PIX_W-1:0];
  endfunction

  assign corr = apply_offset(raw, acc);
endmodule

// File: rtl/blc_accum.sv
module blc_accum #(
  parameter int PIX_W   = 10,
  parameter int ACC_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int GAIN_SH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic [PIX_W-1:0]        refc,
  input  logic [PIX_W-1:0]        corr,
  output logic signed [ACC_W-1:0] acc
);
  localparam int SW  = ACC_W + 2;
  localparam int SHL = FRAC_W - GAIN_SH;
  localparam logic signed [SW-1:0] AMAX = SW'((1 << (ACC_W - 1)) - 1);
  localparam logic signed [SW-1:0] AMIN = -AMAX;

  // R5: acc + ((ref - corr) / 2^GAIN_SH) in fixed point, held inside +/-AMAX
  function automatic logic signed [ACC_W-1:0] step(logic signed [ACC_W-1:0] a,
                                                   logic [PIX_W-1:0] t,
                                                   logic [PIX_W-1:0] c);
    logic signed [SW-1:0] e;
    logic signed [SW-1:0] s;
    e = $signed({{(SW-PIX_W){1'b0}}, t}) - $signed({{(SW-PIX_W){1'b0}}, c});
    s = $signed({{2{a[ACC_W-1]}}, a}) + (e <<< SHL);
    if (s > AMAX)      return AMAX[ACC_W-1:0];
    else if (s < AMIN) return AMIN[ACC_W-1:0];
    else               return s[ACC_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (upd) acc <= step(acc, refc, corr);
  end

  p_frozen_without_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(acc));
  p_rises_below_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (refc > corr)) |=> acc >= $past(acc));
  p_falls_above_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (refc < corr)) |=> acc <= $past(acc));
endmodule

// File: rtl/black_level_clamp.sv
module black_level_clamp
  import blc_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int ACC_W    = 16,
  parameter int FRAC_W   = 4,
  parameter int GAIN_SH  = 2,
  parameter int REF_STEP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             ob_cal_n,
  input  logic             blank_n,
  input  logic [1:0]       ref_sel,
  output logic             out_vld,
  output logic [PIX_W-1:0] out_data
);
  localparam int NCH = 2;

  par_e                    par;
  logic                    par_bit;
  logic signed [ACC_W-1:0] acc_a [NCH];
  logic signed [ACC_W-1:0] acc_cur;
  logic [PIX_W-1:0]        corr;
  logic [PIX_W-1:0]        refc;
  logic                    cal_upd;
  logic                    armed;

  assign par_bit = (par == PAR_ODD);
  assign refc    = PIX_W'(target_code(ref_sel, REF_STEP));
  assign cal_upd = pix_vld && !ob_cal_n && blank_n;
  assign acc_cur = acc_a[par_bit];

  blc_parity u_par (
    .clk(clk), .rst_n(rst_n), .vld(pix_vld), .blank_n(blank_n), .par(par)
  );

  blc_correct #(.PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_corr (
    .raw(pix_data), .acc(acc_cur), .corr(corr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic upd_ch;
    assign upd_ch = cal_upd && (par_bit == 1'(g));
    blc_accum #(.PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .GAIN_SH(GAIN_SH)) u_acc (
      .clk(clk), .rst_n(rst_n), .upd(upd_ch), .refc(refc), .corr(corr), .acc(acc_a[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      armed    <= 1'b0;
    end else begin
      out_vld <= pix_vld;
      armed   <= 1'b1;
      if (!blank_n)     out_data <= '0;
      else if (pix_vld) out_data <= corr;
    end
  end

  p_vld_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> out_vld == $past(pix_vld));
  p_blank_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> out_data == '0);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !pix_vld) |=> $stable(out_data));
  p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({g_ch[1].upd_ch, g_ch[0].upd_ch}));
endmodule

// File: tb/tb_black_level_clamp.sv
`timescale 1ns/1ps
module tb_black_level_clamp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_vld = 1'b0;
  logic [9:0] pix_data = '0;
  logic       ob_cal_n = 1'b1;
  logic       blank_n = 1'b1;
  logic [1:0] ref_sel = 2'b00;
  logic       out_vld;
  logic [9:0] out_data;

  always #2 clk = ~clk;

  black_level_clamp dut (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_data(pix_data),
    .ob_cal_n(ob_cal_n), .blank_n(blank_n), .ref_sel(ref_sel),
    .out_vld(out_vld), .out_data(out_data)
  );

  typedef struct {
    int    due;
    bit    vld;
    int    data;
    int    lit;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  int   m_acc[2] = '{0, 0};
  int   m_par = 0;
  int   m_out = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int clip(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // Driver: applies one cycle of stimulus and predicts the result.
  task automatic step(bit vld, int raw, bit cal_n, bit blk_n, int sel, string req, int lit = -1);
    int corr;
    exp_t e;
    @(negedge clk);
    pix_vld  = vld;
    pix_data = raw[9:0];
    ob_cal_n = cal_n;
    blank_n  = blk_n;
    ref_sel  = sel[1:0];
    corr = clip(raw + (m_acc[m_par] >>> 4), 0, 1023);
    if (!blk_n)   m_out = 0;
    else if (vld) m_out = corr;
    if (vld && !cal_n && blk_n)
      m_acc[m_par] = clip(m_acc[m_par] + 4 * (16 * (sel + 1) - corr), -32767, 32767);
    if (!blk_n)   m_par = 0;
    else if (vld) m_par ^= 1;
    e.due = cyc + 1; e.vld = vld; e.data = m_out; e.lit = lit; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compares each prediction in the cycle it falls due.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk("R2", int'(out_vld), int'(e.vld));
      chk(e.req, int'(out_data), e.data);
      if (e.lit >= 0) chk("R6", int'(out_data), e.lit);
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", int'(out_vld), 0);
    chk("R1", int'(out_data), 0);
    rst_n = 1'b1;

    // R1/R3: offsets start at zero, pixels pass unchanged
    step(1, 100, 1, 1, 0, "R1");
    step(1, 200, 1, 1, 0, "R1");
    step(1, 1023, 1, 1, 0, "R3");
    step(1, 0, 1, 1, 0, "R3");
    // R2/R3: idle cycles hold data, valid drops
    step(0, 555, 1, 1, 0, "R3");
    step(0, 555, 1, 1, 0, "R3");
    step(1, 517, 1, 1, 0, "R3");

    // R5/R4: calibrate channels with different dark levels, gaps included
    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 3) step(0, 0, 0, 1, 1, "R4");
      step(1, (i % 2) ? 50 : 40, 0, 1, 1, "R5");
    end
    // R8: each channel corrected on its own
    for (int i = 0; i < 6; i++) step(1, (i % 2) ? 50 : 40, 1, 1, 1, "R8");
    // R7: frozen outside calibration
    for (int i = 0; i < 4; i++) step(1, 300, 1, 1, 2, "R7");

    // R9: blanking zeroes output and suppresses calibration
    step(1, 300, 1, 0, 1, "R9");
    step(1, 900, 0, 0, 3, "R9");
    step(0, 900, 0, 0, 3, "R9");
    // R4: parity back to even after blanking
    step(1, 40, 1, 1, 1, "R4");
    step(1, 40, 1, 1, 1, "R4");
    step(1, 40, 1, 1, 1, "R4");

    // R6: each target value
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 120; i++) step(1, 0, 0, 1, s, "R6");
      step(1, 0, 1, 1, s, "R6", 16 * (s + 1));
      step(1, 0, 1, 1, s, "R6", 16 * (s + 1));
    end

    // R10: upper clip with positive offset
    step(1, 1000, 1, 1, 3, "R10");
    step(1, 960, 1, 1, 3, "R10");
    step(1, 958, 1, 1, 3, "R10");
    // R10: lower clip with negative offset
    for (int i = 0; i < 60; i++) step(1, 900, 0, 1, 0, "R5");
    step(1, 10, 1, 1, 0, "R10");
    step(1, 10, 1, 1, 0, "R10");

    repeat (3) step(0, 0, 1, 1, 0, "R3");
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule